// File: doc/BRIEF.md
# Packet Store-and-Replay Buffer with Bit-Flip Injection

This block stands in for a serial storage device in a coded data path. Its receive and transmit sides both use 16-bit words split into two byte lanes, and each lane has a control-character flag. On the receive side, the block waits for a start-of-packet word. It then keeps the payload words that follow in an internal packet buffer and drops any comma idles that arrive in between. A single-cycle send request makes the transmit side play back the oldest stored packet. The packet goes out behind its own start-of-packet word, and the line carries comma idles whenever no packet is being sent.

During playback, an injection window alters the data as it leaves the buffer. The window has a per-lane XOR mask, a first word index and a word count. Payload words inside the window have their selected bits inverted, which imitates radiation upsets in stored data and gives a downstream decoder real errors to correct. A running count of the corrupted byte symbols lets a test environment compare the errors injected with the corrections the decoder reports.

Top module: `serial_store_inject`

## Requirements
- R1: After reset, the transmit side sends comma idles (data 0xBCBC, both control flags 2'b11), `overflow` is 0 and `err_count` is 0.
- R2: Capture begins only on a start-of-packet word (data 0xFBFB, flags 2'b11). Words received before it are not stored, including words where only one lane is flagged.
- R3: Once capture has begun, received comma idles (0xBCBC with flags 2'b11) are dropped and are not counted. Exactly PKT_WORDS other words are stored with their flags, and then the receiver waits for the next start-of-packet word.
- R4: A send request while no complete packet is stored has no effect. The output stays at comma idles.
- R5: A send request seen at a clock edge while the transmitter is idle and a packet is stored puts the start-of-packet word on the output after that edge. The PKT_WORDS stored words follow on the next PKT_WORDS edges, and then comma idles follow.
- R6: Stored packets are played back in the order they arrived, and each one is played back once.
- R7: A played-back word with index i (0-based within the packet) is XORed with `inj_mask` when inj_first <= i < inj_first + inj_len and both of its stored flags are 0. Every other word leaves unchanged.
- R8: A stored word that has any control flag set is never corrupted.
- R9: A start-of-packet word that arrives while PKT_SLOTS complete packets are stored causes that whole packet to be dropped. `overflow` is then set and stays set until reset.
- R10: `err_count` rises, for every corrupted word, by the number of byte lanes whose mask byte is non-zero. It does not change otherwise.
- R11: A send request that arrives while a packet is being played back is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8*LANES (16) | Received word |
| rx_ctrl | input | LANES (2) | Per-lane control-character flags of the received word |
| send | input | 1 | Request to play back the oldest stored packet |
| inj_mask | input | 8*LANES (16) | XOR mask applied to corrupted words |
| inj_first | input | IW (8) | Index of the first word in the injection window |
| inj_len | input | IW (8) | Number of words in the injection window |
| tx_data | output | 8*LANES (16) | Transmitted word |
| tx_ctrl | output | LANES (2) | Per-lane control-character flags of the transmitted word |
| overflow | output | 1 | Sticky flag: a packet was dropped because the buffer was full |
| err_count | output | ERR_W (16) | Number of corrupted byte symbols sent since reset |

## Verification
A send request sampled at edge k shows up as the start-of-packet word after edge k, payload word i follows after edge k+1+i, and idles return after edge k+1+PKT_WORDS. The scoreboard therefore arms itself on the start-of-packet word and compares one queued item on each falling edge after that. `err_count` changes on the same edge as the corrupted word it counts, so the bench reads it only once the expected queue is empty. `overflow` is set on the edge that samples the rejected start-of-packet word and is checked a few cycles after that packet has been driven. Every stimulus is applied one time unit after a rising edge, and every output is sampled on a falling edge.

// File: rtl/serial_store_inject.sv
module serial_store_inject #(
  parameter int LANES     = 2,
  parameter int PKT_WORDS = 255,
  parameter int PKT_SLOTS = 2,
  parameter int ERR_W     = 16,
  localparam int DW    = 8 * LANES,
  localparam int IW    = $clog2(PKT_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rx_data,
  input  logic [LANES-1:0] rx_ctrl,
  input  logic             send,
  input  logic [DW-1:0]    inj_mask,
  input  logic [IW-1:0]    inj_first,
  input  logic [IW-1:0]    inj_len,
  output logic [DW-1:0]    tx_data,
  output logic [LANES-1:0] tx_ctrl,
  output logic             overflow,
  output logic [ERR_W-1:0] err_count
);
  localparam int EW    = DW + LANES;
  localparam int DEPTH = PKT_WORDS * PKT_SLOTS;
  localparam int AW    = $clog2(DEPTH);
  localparam int SW    = $clog2(PKT_SLOTS + 1);
  localparam logic [DW-1:0]    SOP_W  = {LANES{8'hFB}};
  localparam logic [DW-1:0]    IDLE_W = {LANES{8'hBC}};
  localparam logic [LANES-1:0] ALL_K  = '1;

  typedef enum logic [1:0] {RX_HUNT, RX_FILL, RX_DROP} rx_st_t;
  typedef enum logic {TX_IDLE, TX_BODY} tx_st_t;

  logic [EW-1:0] mem [DEPTH];

  rx_st_t        rx_st;
  logic [IW-1:0] rx_idx;
  logic [AW-1:0] wp;
  tx_st_t        tx_st;
  logic [IW-1:0] tx_idx;
  logic [AW-1:0] rp;
  logic [SW-1:0] slots;

  wire rx_is_sop  = (rx_ctrl == ALL_K) && (rx_data == SOP_W);
  wire rx_is_idle = (rx_ctrl == ALL_K) && (rx_data == IDLE_W);
  wire rx_take    = (rx_st != RX_HUNT) && !rx_is_idle;
  wire rx_last    = rx_take && (rx_idx == IW'(PKT_WORDS - 1));
  wire wr_en      = (rx_st == RX_FILL) && rx_take;
  wire commit     = (rx_st == RX_FILL) && rx_last;
  wire full       = (slots == SW'(PKT_SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st    <= RX_HUNT;
      rx_idx   <= '0;
      wp       <= '0;
      overflow <= 1'b0;
    end else begin
      case (rx_st)
        RX_HUNT: if (rx_is_sop) begin
          rx_idx <= '0;
          if (full) begin
            rx_st    <= RX_DROP;
            overflow <= 1'b1;
          end else begin
            rx_st <= RX_FILL;
          end
        end
        default: if (rx_take) begin
          rx_idx <= rx_idx + 1'b1;
          if (rx_last) rx_st <= RX_HUNT;
        end
      endcase
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= {rx_ctrl, rx_data};
  end

  wire [EW-1:0]    rd      = mem[rp];
  wire [LANES-1:0] rd_ctrl = rd[EW-1:DW];
  wire [DW-1:0]    rd_data = rd[DW-1:0];

  wire          go      = (tx_st == TX_IDLE) && send && (slots != '0);
  wire          tx_done = (tx_st == TX_BODY) && (tx_idx == IW'(PKT_WORDS - 1));
  wire [IW:0]   idx_x   = {1'b0, tx_idx};
  wire [IW:0]   win_lo  = {1'b0, inj_first};
  wire [IW:0]   win_hi  = win_lo + {1'b0, inj_len};
  wire          hit     = (tx_st == TX_BODY) && (idx_x >= win_lo) && (idx_x < win_hi)
                          && (rd_ctrl == '0);
  wire [DW-1:0] out_data = hit ? (rd_data ^ inj_mask) : rd_data;

  logic [LANES-1:0] lane_hit;
  logic [ERR_W-1:0] n_err;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = hit && (inj_mask[8*l +: 8] != 8'h00);
  end

  always_comb begin
    n_err = '0;
    for (int l = 0; l < LANES; l++) n_err = n_err + ERR_W'(lane_hit[l]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st     <= TX_IDLE;
      tx_idx    <= '0;
      rp        <= '0;
      tx_data   <= IDLE_W;
      tx_ctrl   <= ALL_K;
      err_count <= '0;
    end else begin
      case (tx_st)
        TX_IDLE: begin
          tx_ctrl <= ALL_K;
          tx_idx  <= '0;
          if (go) begin
            tx_data <= SOP_W;
            tx_st   <= TX_BODY;
          end else begin
            tx_data <= IDLE_W;
          end
        end
        default: begin
          tx_data   <= out_data;
          tx_ctrl   <= rd_ctrl;
          tx_idx    <= tx_idx + 1'b1;
          rp        <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
          err_count <= err_count + n_err;
          if (tx_done) tx_st <= TX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slots <= '0;
    else if (commit && !tx_done) slots <= slots + 1'b1;
    else if (tx_done && !commit) slots <= slots - 1'b1;
  end

  AST_SLOTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slots <= SW'(PKT_SLOTS)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_EMPTY_SEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_IDLE && slots == '0) |=> (tx_data == IDLE_W && tx_ctrl == ALL_K)); // R4
  AST_SOP_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (tx_data == SOP_W && tx_ctrl == ALL_K)); // R5
  AST_BUSY_SEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_BODY && !tx_done && send) |=> tx_data != SOP_W || tx_ctrl != ALL_K || $past(rd_data) == SOP_W); // R11
  AST_FLAGGED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_BODY && rd_ctrl != '0) |=> tx_data == $past(rd_data)); // R8
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_BODY) |=> (err_count - $past(err_count)) <= ERR_W'(LANES)); // R10
  AST_ERR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_IDLE) |=> $stable(err_count)); // R10
endmodule

// File: tb/serial_store_inject_tb.sv
module serial_store_inject_tb;
  localparam int PKT   = 255;
  localparam int SLOTS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_data = 16'hBCBC;
  logic [1:0]  rx_ctrl = 2'b11;
  logic        send = 1'b0;
  logic [15:0] inj_mask = '0;
  logic [7:0]  inj_first = '0;
  logic [7:0]  inj_len = '0;
  logic [15:0] tx_data;
  logic [1:0]  tx_ctrl;
  logic        overflow;
  logic [15:0] err_count;

  always #2 clk = ~clk;

  serial_store_inject u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .send(send),
    .inj_mask(inj_mask), .inj_first(inj_first), .inj_len(inj_len),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl), .overflow(overflow), .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;
  logic [17:0] stored_q[$];
  logic [17:0] exp_q[$];
  int stored_pkts = 0;
  int exp_sops = 0;
  int exp_err = 0;
  bit mon_on = 1'b0;
  bit in_pkt = 1'b0;
  int widx = 0;
  logic [17:0] e;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (in_pkt) begin
        e = exp_q.pop_front();
        check({tx_ctrl, tx_data} == e, "R5 R6 R7 R8", "payload word", {14'd0, tx_ctrl, tx_data}, {14'd0, e});
        widx++;
        if (widx == PKT) in_pkt = 1'b0;
      end else if (tx_ctrl == 2'b11 && tx_data == 16'hFBFB) begin
        check(exp_sops > 0, "R4 R11", "unexpected start word", 32'd1, 32'd0);
        exp_sops--;
        in_pkt = 1'b1;
        widx = 0;
      end else begin
        check(tx_ctrl == 2'b11 && tx_data == 16'hBCBC, "R5", "idle between packets",
              {14'd0, tx_ctrl, tx_data}, 32'h3BCBC);
      end
    end
  end

  task automatic put(input logic [1:0] c, input logic [15:0] d);
    rx_ctrl = c;
    rx_data = d;
    @(posedge clk); #1;
  endtask

  task automatic rx_packet(input int seed);
    bit keep;
    keep = stored_pkts < SLOTS;
    if (keep) stored_pkts++;
    put(2'b11, 16'hFBFB);
    for (int i = 0; i < PKT; i++) begin
      logic [1:0]  c;
      logic [15:0] d;
      if (i % 50 == 7) put(2'b11, 16'hBCBC);
      c = (i % 37 == 5) ? 2'b01 : ((i % 61 == 20) ? 2'b10 : 2'b00);
      d = 16'(i * 16'h0107 + seed * 16'h1111);
      put(c, d);
      if (keep) stored_q.push_back({c, d});
    end
    put(2'b11, 16'hBCBC);
  endtask

  task automatic do_send();
    if (stored_pkts > 0) begin
      stored_pkts--;
      for (int i = 0; i < PKT; i++) begin
        logic [17:0] w;
        w = stored_q.pop_front();
        if (i >= int'(inj_first) && i < int'(inj_first) + int'(inj_len) && w[17:16] == 2'b00) begin
          w[15:0] = w[15:0] ^ inj_mask;
          exp_err += int'(inj_mask[15:8] != 0) + int'(inj_mask[7:0] != 0);
        end
        exp_q.push_back(w);
      end
      exp_sops++;
    end
    send = 1'b1;
    @(posedge clk); #1;
    send = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    while (exp_sops > 0 || in_pkt || exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(err_count == 16'(exp_err), req, "error counter", {16'd0, err_count}, exp_err);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check(tx_data == 16'hBCBC && tx_ctrl == 2'b11, "R1", "idle in reset", {14'd0, tx_ctrl, tx_data}, 32'h3BCBC);
    rst_n = 1'b1;
    @(posedge clk); #1;
    mon_on = 1'b1;
    check(overflow == 1'b0, "R1", "overflow after reset", {31'd0, overflow}, 32'd0);
    check(err_count == 16'd0, "R1", "error count after reset", {16'd0, err_count}, 32'd0);

    // R4: nothing stored, send ignored
    do_send();
    repeat (6) @(posedge clk); #1;
    check(tx_data == 16'hBCBC, "R4", "send with empty buffer", {16'd0, tx_data}, 32'h0000BCBC);

    // R2: junk before the start word is not stored
    put(2'b00, 16'h1234);
    put(2'b01, 16'hFB00);
    put(2'b10, 16'hFBFB);
    put(2'b00, 16'hFBFB);
    rx_packet(1);
    do_send();
    drain("R2 R3 R10");

    // R7 R8 R10: window with both lanes, two packets then overflow R9
    inj_mask = 16'h0101; inj_first = 8'd10; inj_len = 8'd40;
    rx_packet(2);
    rx_packet(3);
    check(overflow == 1'b0, "R9", "no overflow with free slot", {31'd0, overflow}, 32'd0);
    rx_packet(4);
    repeat (3) @(posedge clk); #1;
    check(overflow == 1'b1, "R9", "overflow on third packet", {31'd0, overflow}, 32'd1);
    do_send();
    repeat (20) @(posedge clk); #1;
    send = 1'b1;  // R11: ignored mid-replay
    @(posedge clk); #1;
    send = 1'b0;
    drain("R7 R10 R11");
    do_send();    // R6: second stored packet
    drain("R6 R7 R10");

    // R7 boundary: window running past the last word, one lane masked
    inj_mask = 16'hFF00; inj_first = 8'd250; inj_len = 8'd20;
    rx_packet(5);
    do_send();
    drain("R7 R10");

    // R7: empty window
    inj_mask = 16'h8001; inj_first = 8'd0; inj_len = 8'd0;
    rx_packet(6);
    do_send();
    drain("R7 R10");

    // R4 again and R9 stickiness
    do_send();
    repeat (6) @(posedge clk); #1;
    check(tx_data == 16'hBCBC && tx_ctrl == 2'b11, "R4", "late send with empty buffer", {14'd0, tx_ctrl, tx_data}, 32'h3BCBC);
    check(overflow == 1'b1, "R9", "overflow stays set", {31'd0, overflow}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule